// File: doc/BRIEF.md
# Switch Address Table Command Engine

This block holds a small forwarding table of MAC addresses for an Ethernet switch and runs table maintenance commands for a host. The host sees three 32-bit registers. The command register holds the low two address bytes, the function code, the port number, the flush-static selector, the sticky violation flag and the busy bit. The address register holds the upper four address bytes. The entry register holds the forwarding word of an entry.

The host fills the address and entry registers and then writes the command register with busy set. The engine steps through every slot, one slot per clock, and then applies the result. It can load an entry, purge an entry, flush the whole table, flush only the dynamic entries, flush the unicast entries of one port, look up an address, or return the entry that follows an address. Lookup and iteration results are returned in the address and entry registers. Busy falls when the command has finished. A failed load, purge or port flush raises a violation flag, which stays set until the host clears it.

Top module: `addr_table_engine`

## Requirements
- R1: After reset all three registers read zero and the table holds no valid entry.
- R2: A write to the command register (select 0) with bit 3 set and bit 12 clear starts the function in bits [2:0]. It also loads address bytes 4 and 5 from bits [31:24] and [23:16], the port number from [11:8] and the flush-static selector from bit 15. Busy (bit 3) reads high until completion and falls within ENTRIES+2 clock cycles of the write.
- R3: While busy is high, every host write to any register is ignored.
- R4: Load (code 2) stores the entry register word. Entry word layout: [7:0] port bitmap, [15:8] flags, [17:16] priority, [23:20] status, where 15 means static, 7 means dynamic and 0 means empty. If an entry with the same 48-bit address exists, it is overwritten. Otherwise the lowest empty slot is used. If the table is full and the address is absent, the violation flag is set.
- R5: Purge (code 3) empties the slot that matches the address. If no slot matches, the violation flag is set.
- R6: Find (code 7) on a matching address returns that entry's word and leaves the address unchanged. With no match, the address and entry registers both read zero.
- R7: Next (code 6) returns the valid entry whose address, read as an unsigned 48-bit number with byte 0 most significant, is the smallest one above the supplied address. An all-zero input returns the smallest valid entry. If there is none, the address and entry registers read zero.
- R8: Flush-all (code 1) empties every slot. The dynamic flush (code 4) keeps entries with status 15. Neither changes the address registers.
- R9: Port flush (code 5) removes valid unicast entries (bit 0 of byte 0 clear) whose bitmap has the selected port's bit set. Static entries are removed only when the flush-static selector is 1. If nothing is removed, the violation flag is set.
- R10: The violation flag (command bit 12) is set only by codes 2, 3 and 5. It stays set until the host writes the command register with bit 12 set, and that write changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 command, 1 address, 2 entry |
| host_wdata | input | 32 | Host write data |
| cmd_q | output | 32 | Command register contents |
| addr_q | output | 32 | Address bytes 0..3, byte 0 in [31:24] |
| entry_q | output | 32 | Entry word register |

## Verification
The bound checker watches four things on every cycle: the busy duration bound, that the function code holds while busy, that the violation flag stays set until the clearing write, and that the flag only rises at the end of a load, purge or port flush. It also checks that flush commands leave the address registers untouched. Table contents cannot be seen at the ports. Overwrite-on-match, full-table detection, static-aware flushing and the address ordering of next are shown only by the bench's scenarios, which read the table back through find and next.

// File: rtl/addr_table_engine.sv
module addr_table_engine #(
  parameter int ENTRIES = 16,
  parameter int PORTS   = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [1:0]  host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] cmd_q,
  output logic [31:0] addr_q,
  output logic [31:0] entry_q
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [47:0] t_addr [ENTRIES];
  logic [23:0] t_word [ENTRIES];

  logic [31:0] key_hi;
  logic [15:0] key_lo;
  logic [23:0] ent;
  logic [3:0]  port;
  logic [2:0]  func;
  logic        fst, viol, busy, fin;
  logic [IW-1:0] idx, hit_idx, free_idx;
  logic        hit, freef, nf, removed;
  logic [47:0] nxt_addr;
  logic [23:0] nxt_word;

  wire [47:0] key = {key_hi, key_lo};
  wire [47:0] ca  = t_addr[idx];
  wire [23:0] cw  = t_word[idx];
  wire [3:0]  cs  = cw[23:20];
  wire        cv  = cs != 4'h0;
  wire        on_port = (32'(port) < PORTS) && cw[port];
  wire        rm_port = cv && on_port && !ca[40] && (cs != 4'hF || fst);
  wire        is_hit  = cv && ca == key;
  wire        nxt_ok  = cv && (ca > key || key == 48'h0) && (!nf || ca < nxt_addr);
  wire        hc      = host_we && !busy;
  wire        unused_bits = ^{host_wdata[14:13], host_wdata[7:4]};

  assign cmd_q   = {key_lo, fst, 2'b00, viol, port, 4'b0000, busy, func};
  assign addr_q  = key_hi;
  assign entry_q = {8'h00, ent};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_hi <= '0; key_lo <= '0; ent <= '0; port <= '0; func <= '0;
      fst <= 1'b0; viol <= 1'b0; busy <= 1'b0; fin <= 1'b0;
      idx <= '0; hit_idx <= '0; free_idx <= '0;
      hit <= 1'b0; freef <= 1'b0; nf <= 1'b0; removed <= 1'b0;
      nxt_addr <= '0; nxt_word <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        t_addr[i] <= '0;
        t_word[i] <= '0;
      end
    end else if (hc) begin
      case (host_sel)
        2'd0: begin
          if (host_wdata[12]) begin
            viol <= 1'b0;
          end else begin
            key_lo  <= host_wdata[31:16];
            fst     <= host_wdata[15];
            port    <= host_wdata[11:8];
            func    <= host_wdata[2:0];
            busy    <= host_wdata[3];
            idx     <= '0;
            fin     <= 1'b0;
            hit     <= 1'b0;
            freef   <= 1'b0;
            nf      <= 1'b0;
            removed <= 1'b0;
          end
        end
        2'd1: key_hi <= host_wdata;
        2'd2: ent    <= host_wdata[23:0];
        default: ;
      endcase
    end else if (busy && !fin) begin
      if (is_hit && !hit) begin
        hit     <= 1'b1;
        hit_idx <= idx;
      end
      if (!cv && !freef) begin
        freef    <= 1'b1;
        free_idx <= idx;
      end
      if (nxt_ok) begin
        nf       <= 1'b1;
        nxt_addr <= ca;
        nxt_word <= cw;
      end
      case (func)
        3'd1: t_word[idx][23:20] <= 4'h0;
        3'd4: if (cs != 4'hF) t_word[idx][23:20] <= 4'h0;
        3'd5: if (rm_port) begin
          t_word[idx][23:20] <= 4'h0;
          removed <= 1'b1;
        end
        default: ;
      endcase
      if (idx == LAST) fin <= 1'b1;
      else idx <= idx + 1'b1;
    end else if (busy) begin
      busy <= 1'b0;
      fin  <= 1'b0;
      case (func)
        3'd2: begin
          if (hit) begin
            t_addr[hit_idx] <= key;
            t_word[hit_idx] <= ent;
          end else if (freef) begin
            t_addr[free_idx] <= key;
            t_word[free_idx] <= ent;
          end else begin
            viol <= 1'b1;
          end
        end
        3'd3: begin
          if (hit) t_word[hit_idx][23:20] <= 4'h0;
          else viol <= 1'b1;
        end
        3'd5: if (!removed) viol <= 1'b1;
        3'd6: begin
          if (nf) begin
            {key_hi, key_lo} <= nxt_addr;
            ent <= nxt_word;
          end else begin
            {key_hi, key_lo} <= '0;
            ent <= '0;
          end
        end
        3'd7: begin
          if (hit) begin
            ent <= t_word[hit_idx];
          end else begin
            {key_hi, key_lo} <= '0;
            ent <= '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module addr_table_engine_chk #(
  parameter int ENTRIES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [1:0]  host_sel,
  input logic [31:0] host_wdata,
  input logic [31:0] cmd_q,
  input logic [31:0] addr_q
);
  localparam int CW = $clog2(ENTRIES + 3) + 1;
  logic [CW-1:0] bcnt;
  wire busy = cmd_q[3];
  wire [2:0] fn = cmd_q[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else bcnt <= '0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> 32'(bcnt) <= ENTRIES); // R2

  AST_FUNC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fn)); // R3

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[12] && !(host_we && host_sel == 2'd0 && host_wdata[12] && !busy)) |=> cmd_q[12]); // R10

  AST_VIOL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_q[12]) |-> ($fell(busy) && (fn == 3'd2 || fn == 3'd3 || fn == 3'd5))); // R10

  AST_FLUSH_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && (fn == 3'd1 || fn == 3'd4 || fn == 3'd5))
      |-> ($stable(addr_q) && $stable(cmd_q[31:16]))); // R8
endmodule

bind addr_table_engine addr_table_engine_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
  .host_wdata(host_wdata), .cmd_q(cmd_q), .addr_q(addr_q)
);

// File: tb/addr_table_engine_test.sv
`timescale 1ns/1ps
module addr_table_engine_test;
  localparam int N = 16;
  logic clk = 1'b0, rst_n = 1'b0, host_we = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] cmd_q, addr_q, entry_q;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  addr_table_engine #(.ENTRIES(N), .PORTS(7)) uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .cmd_q(cmd_q), .addr_q(addr_q), .entry_q(entry_q));

  always #2.5 clk = ~clk;

  localparam logic [47:0] A = 48'h0011_2233_4455;
  localparam logic [47:0] B = 48'h0200_0000_0001;
  localparam logic [47:0] C = 48'h0100_5E00_0001;
  localparam logic [47:0] D = 48'h0A0B_0C0D_0E0F;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (cmd_q[3] && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R2 busy duration", 64'(n <= N + 2), 64'd1);
  endtask

  task automatic run(logic [2:0] f, logic [47:0] a, logic [23:0] e,
                     logic [3:0] p = 4'd0, logic fs = 1'b0);
    wr(2'd1, a[47:16]);
    wr(2'd2, {8'h00, e});
    wr(2'd0, {a[15:0], fs, 2'b00, 1'b0, p, 4'b0000, 1'b1, f});
    wait_done();
  endtask

  function automatic logic [47:0] raddr();
    return {addr_q, cmd_q[31:16]};
  endfunction

  task automatic expect_find(string req, logic [47:0] a, logic [47:0] ea, logic [23:0] ee);
    run(3'd7, a, 24'h0);
    chk(req, {16'h0, raddr()}, {16'h0, ea});
    chk(req, {32'h0, entry_q}, {40'h0, ee});
  endtask

  task automatic expect_next(string req, logic [47:0] a, logic [47:0] ea, logic [23:0] ee);
    run(3'd6, a, 24'h0);
    chk(req, {16'h0, raddr()}, {16'h0, ea});
    chk(req, {32'h0, entry_q}, {40'h0, ee});
  endtask

  task automatic clear_viol();
    wr(2'd0, 32'h0000_1000);
  endtask

  task automatic t_reset();
    chk("R1 cmd reset", {32'h0, cmd_q}, 64'h0);
    chk("R1 addr reset", {32'h0, addr_q}, 64'h0);
    chk("R1 entry reset", {32'h0, entry_q}, 64'h0);
    expect_next("R1 empty table", 48'h0, 48'h0, 24'h0);
  endtask

  task automatic t_load_find();
    run(3'd2, A, 24'h70A504);
    run(3'd2, B, 24'hF00004);
    run(3'd2, C, 24'h700004);
    chk("R4 no violation", {63'h0, cmd_q[12]}, 64'h0);
    expect_find("R6 find B", B, B, 24'hF00004);
    expect_find("R6 find A", A, A, 24'h70A504);
    expect_find("R6 find missing", D, 48'h0, 24'h0);
    run(3'd2, A, 24'h731102);
    expect_find("R4 overwrite", A, A, 24'h731102);
  endtask

  task automatic t_next();
    expect_next("R7 first", 48'h0, A, 24'h731102);
    expect_next("R7 after A", A, C, 24'h700004);
    expect_next("R7 after C", C, B, 24'hF00004);
    expect_next("R7 end", B, 48'h0, 24'h0);
    expect_next("R7 between", 48'h0050_0000_0000, C, 24'h700004);
  endtask

  task automatic t_purge();
    run(3'd3, C, 24'h0);
    chk("R5 purge hit no violation", {63'h0, cmd_q[12]}, 64'h0);
    expect_find("R5 purged", C, 48'h0, 24'h0);
    run(3'd3, C, 24'h0);
    chk("R5 purge miss violation", {63'h0, cmd_q[12]}, 64'h1);
    expect_find("R10 sticky find", A, A, 24'h731102);
    chk("R10 sticky", {63'h0, cmd_q[12]}, 64'h1);
    clear_viol();
    chk("R10 cleared", {63'h0, cmd_q[12]}, 64'h0);
    chk("R10 clear keeps func", {61'h0, cmd_q[2:0]}, 64'd7);
  endtask

  task automatic t_flush_dyn();
    run(3'd4, 48'h0, 24'h0);
    chk("R8 no violation", {63'h0, cmd_q[12]}, 64'h0);
    expect_find("R8 dynamic gone", A, 48'h0, 24'h0);
    expect_find("R8 static kept", B, B, 24'hF00004);
  endtask

  task automatic t_port_flush();
    run(3'd1, 48'h0, 24'h0);
    run(3'd2, A, 24'h700004);
    run(3'd2, B, 24'hF00004);
    run(3'd2, C, 24'h700004);
    run(3'd2, D, 24'h700008);
    run(3'd5, 48'h0, 24'h0, 4'd2, 1'b0);
    chk("R9 removed no violation", {63'h0, cmd_q[12]}, 64'h0);
    expect_find("R9 dynamic unicast gone", A, 48'h0, 24'h0);
    expect_find("R9 static kept", B, B, 24'hF00004);
    expect_find("R9 multicast kept", C, C, 24'h700004);
    expect_find("R9 other port kept", D, D, 24'h700008);
    run(3'd5, 48'h0, 24'h0, 4'd2, 1'b0);
    chk("R9 nothing removed violation", {63'h0, cmd_q[12]}, 64'h1);
    clear_viol();
    run(3'd5, 48'h0, 24'h0, 4'd2, 1'b1);
    chk("R9 static flush no violation", {63'h0, cmd_q[12]}, 64'h0);
    expect_find("R9 static gone", B, 48'h0, 24'h0);
    expect_find("R9 multicast still kept", C, C, 24'h700004);
  endtask

  task automatic t_flush_all();
    run(3'd1, 48'h0, 24'h0);
    chk("R8 flush all no violation", {63'h0, cmd_q[12]}, 64'h0);
    expect_next("R8 table empty", 48'h0, 48'h0, 24'h0);
  endtask

  task automatic t_full();
    for (int i = 0; i < N; i++) run(3'd2, 48'h1000 + 48'(i), 24'h700001);
    chk("R4 filled no violation", {63'h0, cmd_q[12]}, 64'h0);
    run(3'd2, 48'h9999, 24'h700001);
    chk("R4 full violation", {63'h0, cmd_q[12]}, 64'h1);
    clear_viol();
    expect_find("R4 not stored", 48'h9999, 48'h0, 24'h0);
    run(3'd2, 48'h1003, 24'hF00002);
    chk("R4 overwrite on full", {63'h0, cmd_q[12]}, 64'h0);
    expect_find("R4 overwrite on full", 48'h1003, 48'h1003, 24'hF00002);
  endtask

  task automatic t_busy_ignore();
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd0, {16'h1005, 12'h000, 1'b1, 3'd7});
    wr(2'd1, 32'hDEAD_BEEF);
    wr(2'd2, 32'h00F0_0003);
    wr(2'd0, {16'h7777, 12'h000, 1'b1, 3'd1});
    wait_done();
    chk("R3 addr kept", {16'h0, raddr()}, 64'h1005);
    chk("R3 entry kept", {32'h0, entry_q}, 64'h700001);
    chk("R3 func kept", {61'h0, cmd_q[2:0]}, 64'd7);
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_find();
    t_next();
    t_purge();
    t_flush_dyn();
    t_port_flush();
    t_flush_all();
    t_full();
    t_busy_ignore();
    done = 1;
    finish_up();
  end
endmodule